// File: doc/BRIEF.md
# Debug Run Control Register

This block is the processor's debug control register together with the logic that decides whether the core may fetch instructions. A debugger halts the core by setting a halt bit and resumes it by clearing that bit. A breakpoint hit can also stop the core, but only when a breakpoint-halt enable bit is set. While the core is halted, a step request lets exactly one instruction run. The request clears itself when the core reports that the instruction has completed, and the core then stays halted.

The same 8-bit register holds three enable bits that other debug logic uses: breakpoint comparator enable, debug serial link enable and response checksum enable. This block only drives these enables out. It does not contain the comparators, the serial link or the checksum logic. One read-only bit shows the state of the debug-enable input, and one reserved bit always reads as zero.

The register has a single write strobe with write data and a readback path with no wait states. The core side uses plain control pins: a breakpoint-hit pulse, an instruction-complete pulse and a fetch-enable level. None of these carry a data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `dbg_run_ctrl`

## Requirements
- R1: After reset every writable bit reads 0, the fetch enable is high and the three enable outputs are low. The register map is: bit 0 halt, bit 1 step, bit 2 breakpoint enable, bit 3 breakpoint-halt enable, bit 4 serial link enable, bit 5 checksum enable, bit 6 reserved, bit 7 debug-enable status.
- R2: A write with bit 0 set drops the fetch enable from the cycle after the write, provided no step is active. A write with bit 0 clear raises the fetch enable from the cycle after the write.
- R3: A breakpoint-hit pulse while bit 3 reads 1 sets bit 0 in the next cycle. This takes priority over a write in the same cycle that clears bit 0.
- R4: A breakpoint-hit pulse while bit 3 reads 0 leaves bit 0 unchanged.
- R5: A write with bits 0 and 1 both set, while bit 0 already reads 1, sets bit 1 and raises the fetch enable from the next cycle. Bit 1 stays set, and writes with bit 1 clear do not cancel it, until the cycle after an instruction-complete pulse. After that pulse bit 1 reads 0, bit 0 reads 1 and the fetch enable is low.
- R6: A write with bit 1 set is ignored when bit 0 read 0 before the write, or when the written bit 0 is 0. Bit 1 then reads 0.
- R7: A write that clears bit 0, with no breakpoint halt in the same cycle, cancels an active step. From the next cycle bit 1 reads 0 and the fetch enable is high.
- R8: The breakpoint enable, link enable and checksum enable outputs follow bits 2, 4 and 5 of the last write, from the cycle after that write.
- R9: Bit 6 always reads 0. Bit 7 always reads the debug-enable input at once. Writes affect neither bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register readback |
| dbg_enable_i | input | 1 | Debug-enable status, shown at bit 7 |
| bp_hit_i | input | 1 | Breakpoint hit pulse from the comparators |
| instr_done_i | input | 1 | Instruction-complete pulse from the core |
| fetch_en_o | output | 1 | Core may fetch instructions when high |
| bp_en_o | output | 1 | Breakpoint comparator enable |
| link_en_o | output | 1 | Debug serial link enable |
| crc_en_o | output | 1 | Response checksum enable |

## Verification
All state sits in one register stage. The effect of a write, a breakpoint pulse or an instruction-complete pulse is therefore due exactly one clock edge after the edge that samples it, and the readback and fetch enable show it immediately after that edge. Bit 7 is combinational and follows its input within the same cycle. The bench drives every input on the falling edge and samples one falling edge later, which places each check half a cycle after the edge where the result becomes due. An exhaustive sweep over all 256 write values, from both a running and a halted start, computes the expected readback arithmetically from the bit map.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;
  localparam int REG_W   = 8;
  // Bit positions within the control register
  localparam int B_HALT  = 0;
  localparam int B_STEP  = 1;
  localparam int CFG_LSB = 2;
  localparam int N_CFG   = 4;
  localparam int B_RSVD  = CFG_LSB + N_CFG;
  localparam int B_STAT  = REG_W - 1;
  // Index of each enable within the configuration bank
  localparam int C_BPEN   = 0;
  localparam int C_BPHALT = 1;
  localparam int C_LINK   = 2;
  localparam int C_CRC    = 3;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [N_CFG-1:0] cfg_t;

  typedef struct packed {
    logic halt;
    logic step;
  } run_state_t;
endpackage

// File: rtl/dbg_cfg_bits.sv
module dbg_cfg_bits
  import dbg_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cfg_t wr_cfg,
  output cfg_t cfg_q
);
  for (genvar i = 0; i < N_CFG; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q[i] <= 1'b0;
      else if (wr_en) cfg_q[i] <= wr_cfg[i];
    end
  end
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
  import dbg_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_halt,
  input  logic       wr_step,
  input  logic       bp_hit,
  input  logic       bp_halt_en,
  input  logic       instr_done,
  output run_state_t st_q,
  output logic       fetch_en
);
  run_state_t st_d;
  logic bp_stop;
  logic step_accept;

  assign bp_stop     = bp_hit && bp_halt_en;
  assign step_accept = wr_en && wr_step && wr_halt && st_q.halt;

  always_comb begin
    st_d = st_q;
    // halt: a breakpoint stop outranks any write
    if (bp_stop)    st_d.halt = 1'b1;
    else if (wr_en) st_d.halt = wr_halt;
    // step: ends on completion, may be re-armed, dies with halt
    if (st_q.step && instr_done) st_d.step = 1'b0;
    if (step_accept)             st_d.step = 1'b1;
    if (!st_d.halt)              st_d.step = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign fetch_en = !st_q.halt || st_q.step;
endmodule

// File: rtl/dbg_readback.sv
module dbg_readback
  import dbg_ctrl_pkg::*;
(
  input  run_state_t st,
  input  cfg_t       cfg,
  input  logic       dbg_en,
  output reg_t       rd_data
);
  always_comb begin
    rd_data                   = '0;
    rd_data[B_HALT]           = st.halt;
    rd_data[B_STEP]           = st.step;
    rd_data[CFG_LSB +: N_CFG] = cfg;
    rd_data[B_STAT]           = dbg_en;
  end
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             dbg_enable_i,
  input  logic             bp_hit_i,
  input  logic             instr_done_i,
  output logic             fetch_en_o,
  output logic             bp_en_o,
  output logic             link_en_o,
  output logic             crc_en_o
);
  cfg_t       cfg_q;
  run_state_t st_q;
  logic       unused_wr;

  // reserved and status positions take no write data
  assign unused_wr = ^{wr_data_i[B_RSVD], wr_data_i[B_STAT]};

  dbg_cfg_bits u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en_i),
    .wr_cfg (wr_data_i[CFG_LSB +: N_CFG]),
    .cfg_q  (cfg_q)
  );

  dbg_halt_fsm u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .wr_halt    (wr_data_i[B_HALT]),
    .wr_step    (wr_data_i[B_STEP]),
    .bp_hit     (bp_hit_i),
    .bp_halt_en (cfg_q[C_BPHALT]),
    .instr_done (instr_done_i),
    .st_q       (st_q),
    .fetch_en   (fetch_en_o)
  );

  dbg_readback u_rd (
    .st      (st_q),
    .cfg     (cfg_q),
    .dbg_en  (dbg_enable_i),
    .rd_data (rd_data_o)
  );

  assign bp_en_o   = cfg_q[C_BPEN];
  assign link_en_o = cfg_q[C_LINK];
  assign crc_en_o  = cfg_q[C_CRC];
endmodule

// File: rtl/dbg_run_ctrl_chk.sv
module dbg_run_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_halt,
  input logic wr_step,
  input logic rd_halt,
  input logic rd_step,
  input logic rd_bphalt,
  input logic bp_hit,
  input logic instr_done,
  input logic fetch_en
);
  p_halt_stops_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_halt && !rd_step |-> !fetch_en);

  p_bp_sets_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit && rd_bphalt |=> rd_halt);

  p_bp_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit && !rd_bphalt && !wr_en |=> $stable(rd_halt));

  p_step_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step && instr_done && !wr_en |=> !rd_step && rd_halt && !fetch_en);

  p_step_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_step && !rd_halt |=> !rd_step);

  p_resume_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_halt && !(bp_hit && rd_bphalt) |=> !rd_step && fetch_en);
endmodule

bind dbg_run_ctrl dbg_run_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en_i),
  .wr_halt    (wr_data_i[0]),
  .wr_step    (wr_data_i[1]),
  .rd_halt    (rd_data_o[0]),
  .rd_step    (rd_data_o[1]),
  .rd_bphalt  (rd_data_o[3]),
  .bp_hit     (bp_hit_i),
  .instr_done (instr_done_i),
  .fetch_en   (fetch_en_o)
);

// File: tb/dbg_run_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_run_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       dbg_en = 1'b0;
  logic       bp_hit = 1'b0;
  logic       done = 1'b0;
  logic       fetch_en, bp_en, link_en, crc_en;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbg_run_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .dbg_enable_i(dbg_en), .bp_hit_i(bp_hit),
    .instr_done_i(done), .fetch_en_o(fetch_en), .bp_en_o(bp_en),
    .link_en_o(link_en), .crc_en_o(crc_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write in one cycle; returns at the falling edge after the sampling edge
  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_rd;
    logic h, s;
    idle(3);
    // R1 reset state
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 fetch", fetch_en, 1'b1);
    chk("R1 enables", {bp_en, link_en, crc_en}, 3'b000);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release", rd_data, 8'h00);

    // R9 status follows input at once, writes do not touch bits 6/7
    dbg_en = 1'b1; #1;
    chk("R9 status", rd_data[7], 1'b1);
    @(negedge clk);
    wr(8'hC0);
    chk("R9 rsvd/status write", rd_data, 8'h80);
    dbg_en = 1'b0; wr(8'hFF);
    chk("R9 status low", rd_data[7:6], 2'b00);
    dbg_en = 1'b1;

    // R2 R6 R8 R9 exhaustive sweep from running and halted
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++) begin
        wr(8'h00);
        wr(p[0] ? 8'h01 : 8'h00);
        wr(v[7:0]);
        h = v[0];
        s = v[0] & v[1] & p[0];
        exp_rd = {1'b1, 1'b0, v[5:2], s, h};
        chk("R2/R6/R9 sweep rd", rd_data, exp_rd);
        chk("R2 sweep fetch", fetch_en, !h || s);
        chk("R8 sweep enables", {bp_en, link_en, crc_en}, {v[2], v[4], v[5]});
      end
    end

    // R3 breakpoint halt
    wr(8'h08);
    bp_hit = 1'b1; @(negedge clk); bp_hit = 1'b0;
    chk("R3 halt set", rd_data[0], 1'b1);
    chk("R3 fetch low", fetch_en, 1'b0);
    wr_en = 1'b1; wr_data = 8'h08; bp_hit = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bp_hit = 1'b0;
    chk("R3 priority over write", rd_data, 8'h89);

    // R4 breakpoint with halt-enable off
    wr(8'h04);
    bp_hit = 1'b1; @(negedge clk); bp_hit = 1'b0;
    chk("R4 running unchanged", rd_data[0], 1'b0);
    chk("R4 fetch stays", fetch_en, 1'b1);
    wr(8'h05);
    bp_hit = 1'b1; @(negedge clk); bp_hit = 1'b0;
    chk("R4 halted unchanged", rd_data[0], 1'b1);

    // R5 single step
    wr(8'h01);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk("R5 done without step", {rd_data[1:0], fetch_en}, 3'b010);
    wr(8'h03);
    chk("R5 step on", {rd_data[1:0], fetch_en}, 3'b111);
    idle(3);
    chk("R5 step holds", fetch_en, 1'b1);
    wr(8'h01);
    chk("R5 step not cancelled by write", {rd_data[1:0], fetch_en}, 3'b111);
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk("R5 step over", rd_data, 8'h81);
    chk("R5 fetch low", fetch_en, 1'b0);
    idle(2);
    chk("R5 stays halted", {rd_data[1:0], fetch_en}, 3'b010);

    // R6 step refused while running
    wr(8'h00);
    wr(8'h02);
    chk("R6 step refused", rd_data, 8'h80);

    // R7 resume cancels step
    wr(8'h01);
    wr(8'h03);
    wr(8'h00);
    chk("R7 cancel", rd_data, 8'h80);
    chk("R7 fetch", fetch_en, 1'b1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule